// File: doc/BRIEF.md
# Paced Cycle-Steal DMA Bus Pacer

This block decides when one DMA channel may own the shared bus while it runs in cycle-steal fashion. Software arms it with a count of transfer units, a unit size and a pacing mode. While the active-low transfer request is held asserted, the block raises a bus request. Once the grant arrives it runs a read beat and then a write beat for each beat of the unit. After the last write of the unit it drops the bus request again.

In the two spaced modes, dropping the bus starts a hold-off. During the hold-off the channel may not ask for the bus again, which keeps the channel's share of bus time low. If the transfer request is seen at any time during the hold-off, that request is kept and served when the hold-off ends. When the last unit finishes, the block pulses a completion flag and goes quiet until it is armed again. Address generation and the data path belong to neighbouring logic, which follows the read and write strobes.

Top module: `cs_dma_pacer`

## Requirements
- R1: The bus request falls in the cycle right after the write strobe of a unit's final beat, for every unit and in every mode.
- R2: With pace code 1 (short spacing, default 16), the bus request stays low for exactly 16 cycles between two units when the transfer request is held asserted.
- R3: With pace code 2 (long spacing, default 64), the bus request stays low for exactly 64 cycles between two units when the transfer request is held asserted.
- R4: With pace code 0, or with the reserved code 3, there is no hold-off. The bus request is low for exactly one cycle between units when the transfer request is held asserted.
- R5: When `burst_elsewhere` is 1 at arm time, both spaced codes fall back to the unspaced behaviour of R4.
- R6: Each beat is exactly one cycle of `rd_strobe` followed at once by one cycle of `wr_strobe`, with the bus request held high throughout.
- R7: Size codes 0, 1 and 2 (byte, halfword, word) move one beat per unit. Size code 3 (16-byte block) moves four beats per unit before the bus is released.
- R8: The transfer request `req_n` is active low and level sensitive. An armed block that is not in hold-off raises the bus request only while `req_n` is 0.
- R9: A `req_n` low level seen during the hold-off is remembered. The next unit starts when the hold-off ends, even if `req_n` has returned high by then.
- R10: `done` is high for exactly one cycle, in the cycle after the final write strobe of the last unit. `busy` is low in that same cycle.
- R11: While idle, `req_n` has no effect and the bus request stays low. An `arm` pulse while busy is ignored and does not change the number of units moved.
- R12: The bus request stays high until `bus_gnt` is sampled high. The first read strobe of a unit comes in the cycle after that sample.
- R13: Arming with a unit count of 0 gives a `done` pulse in the next cycle with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Start pulse; sampled only while idle |
| unit_count | input | CNT_W | Number of units to move, sampled at arm |
| unit_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 16-byte block |
| pace_mode | input | 2 | Pace code: 0 none, 1 short, 2 long, 3 reserved (none) |
| burst_elsewhere | input | 1 | Some other channel holds the bus in burst fashion; forces no spacing |
| req_n | input | 1 | Transfer request, active low level |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| rd_strobe | output | 1 | Read beat in progress |
| wr_strobe | output | 1 | Write beat in progress |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Armed and not yet complete |

## Verification
The hardest situation to reach from the ports is a remembered request: the transfer request has to rise before the hold-off begins, dip low for a single cycle in the middle of the hold-off, and be high again when the hold-off ends. The bench waits for the first write strobe, lifts `req_n` on the next cycle, pulses it for one cycle a few cycles later, and then expects the second unit to start exactly 16 cycles after the release. A behavioural model steps along with the design on every clock, and the bench also measures bus-request gaps and grant-to-read delays directly at the ports.

// File: rtl/cs_pace_pkg.sv
package cs_pace_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READY,
      PH_ASK,
      PH_READ,
      PH_WRITE,
      PH_HOLD
   } phase_t;

   typedef enum logic [1:0] {
      PACE_NONE,
      PACE_SHORT,
      PACE_LONG
   } pace_t;

   // Spacing is only legal when no other channel owns the bus in bursts.
   function automatic pace_t pick_pace(input logic [1:0] code, input logic burst_seen);
      pace_t p;
      if (burst_seen) p = PACE_NONE;
      else begin
         case (code)
            2'd1:    p = PACE_SHORT;
            2'd2:    p = PACE_LONG;
            default: p = PACE_NONE;
         endcase
      end
      return p;
   endfunction

endpackage

// File: rtl/cs_holdoff_timer.sv
module cs_holdoff_timer
   import cs_pace_pkg::*;
#(
   parameter int GAP_SHORT = 16,
   parameter int GAP_LONG  = 64
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  pace_t pace,
   output logic  expired
);
   localparam int CW = $clog2(GAP_LONG);

   generate
      if (GAP_SHORT < 1 || GAP_LONG < 2 || GAP_LONG < GAP_SHORT) begin : g_bad_gap
         $error("cs_holdoff_timer: gap parameters out of range");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load)             cnt_q <= (pace == PACE_LONG) ? CW'(GAP_LONG - 1) : CW'(GAP_SHORT - 1);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_RUNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/cs_unit_tracker.sv
module cs_unit_tracker #(
   parameter int CNT_W       = 8,
   parameter int BURST_BEATS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count,
   input  logic             wide_unit,
   input  logic             beat_done,
   output logic             last_beat,
   output logic             final_unit
);
   generate
      if (CNT_W < 1 || BURST_BEATS < 1) begin : g_bad_cfg
         $error("cs_unit_tracker: illegal width or beat count");
      end
   endgenerate

   logic [CNT_W-1:0] rem_q;
   logic             wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         wide_q <= 1'b0;
      end else if (load) begin
         rem_q  <= count;
         wide_q <= wide_unit;
      end else if (beat_done && last_beat) begin
         rem_q  <= rem_q - 1'b1;
      end
   end

   generate
      if (BURST_BEATS == 1) begin : g_single_beat
         assign last_beat = 1'b1;
      end else begin : g_multi_beat
         localparam int BW = $clog2(BURST_BEATS);
         logic [BW-1:0] beat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     beat_q <= '0;
            else if (load)                  beat_q <= '0;
            else if (beat_done && last_beat) beat_q <= '0;
            else if (beat_done)             beat_q <= beat_q + 1'b1;
         end
         assign last_beat = !wide_q || (beat_q == BW'(BURST_BEATS - 1));
      end
   endgenerate

   assign final_unit = (rem_q == CNT_W'(1));

   AST_NO_BEAT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      beat_done |-> (rem_q != '0)); // R10

endmodule

// File: rtl/cs_dma_pacer.sv
module cs_dma_pacer
   import cs_pace_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int GAP_SHORT   = 16,
   parameter int GAP_LONG    = 64,
   parameter int BURST_BEATS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CNT_W-1:0] unit_count,
   input  logic [1:0]       unit_size,
   input  logic [1:0]       pace_mode,
   input  logic             burst_elsewhere,
   input  logic             req_n,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             rd_strobe,
   output logic             wr_strobe,
   output logic             done,
   output logic             busy
);
   localparam int RW = $clog2(GAP_LONG + 2);

   phase_t state_q, state_d;
   pace_t  pace_q;
   logic   pend_q, done_q, done_d;
   logic   start, tmr_load, expired, last_beat, final_unit, beat_done;

   assign start     = arm && (state_q == PH_IDLE);
   assign beat_done = (state_q == PH_WRITE);

   cs_unit_tracker #(.CNT_W(CNT_W), .BURST_BEATS(BURST_BEATS)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .count      (unit_count),
      .wide_unit  (unit_size == 2'd3),
      .beat_done  (beat_done),
      .last_beat  (last_beat),
      .final_unit (final_unit)
   );

   cs_holdoff_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .pace    (pace_q),
      .expired (expired)
   );

   always_comb begin
      state_d  = state_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      case (state_q)
         PH_IDLE: begin
            if (arm) begin
               if (unit_count == '0) done_d  = 1'b1;
               else                  state_d = PH_READY;
            end
         end
         PH_READY: if (!req_n)   state_d = PH_ASK;
         PH_ASK:   if (bus_gnt)  state_d = PH_READ;
         PH_READ:  state_d = PH_WRITE;
         PH_WRITE: begin
            if (!last_beat)             state_d = PH_READ;
            else if (final_unit) begin
               done_d  = 1'b1;
               state_d = PH_IDLE;
            end else if (pace_q != PACE_NONE) begin
               tmr_load = 1'b1;
               state_d  = PH_HOLD;
            end else                    state_d = PH_READY;
         end
         PH_HOLD: if (expired) state_d = (pend_q || !req_n) ? PH_ASK : PH_READY;
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         pace_q  <= PACE_NONE;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (start) pace_q <= pick_pace(pace_mode, burst_elsewhere);
         if (state_q == PH_HOLD && !expired && !req_n) pend_q <= 1'b1;
         else if (state_q != PH_HOLD || expired)      pend_q <= 1'b0;
      end
   end

   assign bus_req   = (state_q == PH_ASK) || (state_q == PH_READ) || (state_q == PH_WRITE);
   assign rd_strobe = (state_q == PH_READ);
   assign wr_strobe = (state_q == PH_WRITE);
   assign done      = done_q;
   assign busy      = (state_q != PH_IDLE);

   // Run length of the released bus, kept only for the spacing check.
   logic [RW-1:0] low_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_run_q <= '0;
      else if (bus_req)                    low_run_q <= '0;
      else if (low_run_q != RW'(GAP_LONG)) low_run_q <= low_run_q + 1'b1;
   end

   AST_UNIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && last_beat) |=> !bus_req); // R1
   AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && $past(state_q) == PH_HOLD) |->
      (low_run_q >= ((pace_q == PACE_LONG) ? RW'(GAP_LONG) : RW'(GAP_SHORT)))); // R2
   AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> wr_strobe); // R6
   AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !$past(wr_strobe)) |-> $past(bus_gnt)); // R12
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req); // R11
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_strobe, wr_strobe})); // R6

endmodule

// File: tb/cs_dma_pacer_test.sv
module cs_dma_pacer_test;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic [CNT_W-1:0] unit_count = '0;
   logic [1:0] unit_size = 2'd0;
   logic [1:0] pace_mode = 2'd0;
   logic burst_elsewhere = 1'b0;
   logic req_n = 1'b1;
   logic bus_gnt = 1'b0;
   logic bus_req, rd_strobe, wr_strobe, done, busy;

   always #2 clk = ~clk;

   cs_dma_pacer #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .unit_count(unit_count),
      .unit_size(unit_size), .pace_mode(pace_mode), .burst_elsewhere(burst_elsewhere),
      .req_n(req_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .rd_strobe(rd_strobe),
      .wr_strobe(wr_strobe), .done(done), .busy(busy)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: phase names are bench-local.
   int m_ph = 0;      // 0 idle,1 waiting,2 asking,3 reading,4 writing,5 spacing
   int m_rem = 0, m_beat = 0, m_beats = 1, m_gap = 0, m_left = 0;
   bit m_pend = 0, m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_done = 0; m_pend = 0;
      end else begin
         bit dn;
         dn = 0;
         case (m_ph)
            0: if (arm) begin
                  m_beats = (unit_size == 2'd3) ? 4 : 1;
                  if (burst_elsewhere || pace_mode == 2'd0 || pace_mode == 2'd3) m_gap = 0;
                  else m_gap = (pace_mode == 2'd1) ? 16 : 64;
                  if (unit_count == 0) dn = 1;
                  else begin m_rem = int'(unit_count); m_beat = 0; m_ph = 1; end
               end
            1: if (!req_n) m_ph = 2;
            2: if (bus_gnt) m_ph = 3;
            3: m_ph = 4;
            4: if (m_beat < m_beats - 1) begin m_beat++; m_ph = 3; end
               else begin
                  m_beat = 0; m_rem--;
                  if (m_rem == 0) begin dn = 1; m_ph = 0; end
                  else if (m_gap > 0) begin m_left = m_gap; m_pend = 0; m_ph = 5; end
                  else m_ph = 1;
               end
            5: begin
                  if (!req_n) m_pend = 1;
                  m_left--;
                  if (m_left == 0) m_ph = m_pend ? 2 : 1;
               end
            default: m_ph = 0;
         endcase
         m_done = dn;
      end
   end

   // Port monitor and grant source.
   int cyc = 0, gnt_lat = 0, gwait = 0;
   int fall_cyc = 0, rise_cyc = 0, last_gap = -1, rd_cnt = 0, lat_meas = -1;
   bit prev_req = 0, prev_wr = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(bus_req == (m_ph == 2 || m_ph == 3 || m_ph == 4), "R1", "bus_req vs model", bus_req, (m_ph >= 2 && m_ph <= 4));
         chk(rd_strobe == (m_ph == 3), "R6", "rd_strobe vs model", rd_strobe, m_ph == 3);
         chk(wr_strobe == (m_ph == 4), "R6", "wr_strobe vs model", wr_strobe, m_ph == 4);
         chk(done == m_done, "R10", "done vs model", done, m_done);
         chk(busy == (m_ph != 0), "R10", "busy vs model", busy, m_ph != 0);
      end
      if (prev_req && !bus_req) fall_cyc = cyc;
      if (!prev_req && bus_req) begin rise_cyc = cyc; last_gap = cyc - fall_cyc; end
      if (rd_strobe) rd_cnt++;
      if (rd_strobe && !prev_wr) lat_meas = cyc - rise_cyc;
      prev_req = bus_req;
      prev_wr  = wr_strobe;
      if (bus_req) gwait++; else gwait = 0;
      bus_gnt = bus_req && (gwait > gnt_lat);
   end

   task automatic start_run(input int cnt, input int sz, input int pm, input bit bst);
      @(negedge clk);
      unit_count = CNT_W'(cnt); unit_size = 2'(sz); pace_mode = 2'(pm); burst_elsewhere = bst;
      arm = 1'b1; rd_cnt = 0; last_gap = -1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!bus_req && !rd_strobe && !wr_strobe && !done && !busy, "R11", "reset outputs", {bus_req, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 unspaced, byte units
      req_n = 1'b0;
      start_run(3, 0, 0, 0); wait_idle();
      chk(last_gap == 1, "R4", "gap in unspaced mode", last_gap, 1);
      chk(rd_cnt == 3, "R7", "reads for byte units", rd_cnt, 3);

      // R2 short spacing, word units
      start_run(3, 2, 1, 0); wait_idle();
      chk(last_gap == 16, "R2", "short spacing gap", last_gap, 16);

      // R3 long spacing, halfword units
      start_run(2, 1, 2, 0); wait_idle();
      chk(last_gap == 64, "R3", "long spacing gap", last_gap, 64);

      // R7 16-byte units, four beats each
      start_run(2, 3, 1, 0); wait_idle();
      chk(rd_cnt == 8, "R7", "reads for block units", rd_cnt, 8);
      chk(last_gap == 16, "R1", "release only after whole block", last_gap, 16);

      // R5 burst fallback and reserved code
      start_run(3, 0, 2, 1); wait_idle();
      chk(last_gap == 1, "R5", "burst forces unspaced", last_gap, 1);
      start_run(2, 0, 3, 0); wait_idle();
      chk(last_gap == 1, "R4", "reserved code unspaced", last_gap, 1);

      // R12 slow grant
      gnt_lat = 5;
      start_run(2, 2, 0, 0); wait_idle();
      chk(lat_meas == 6, "R12", "grant to first read", lat_meas, 6);
      gnt_lat = 0;
      start_run(1, 2, 0, 0); wait_idle();
      chk(lat_meas == 1, "R12", "immediate grant to read", lat_meas, 1);

      // R8 request level gates the bus request
      req_n = 1'b1;
      start_run(2, 0, 0, 0);
      repeat (10) @(negedge clk);
      chk(!bus_req && busy, "R8", "no bus request while req_n high", bus_req, 0);
      req_n = 1'b0; wait_idle();
      chk(rd_cnt == 2, "R8", "units after request asserted", rd_cnt, 2);

      // R9 request remembered during hold-off
      start_run(2, 2, 1, 0);
      for (int i = 0; i < 200 && !wr_strobe; i++) @(negedge clk);
      @(negedge clk); req_n = 1'b1;
      repeat (4) @(negedge clk); req_n = 1'b0;
      @(negedge clk); req_n = 1'b1;
      wait_idle();
      chk(!busy && rd_cnt == 2, "R9", "remembered request finished run", rd_cnt, 2);
      chk(last_gap == 16, "R9", "remembered request gap", last_gap, 16);

      // R11 requests ignored while idle
      req_n = 1'b0;
      repeat (10) @(negedge clk);
      chk(!bus_req && !busy, "R11", "idle ignores request", bus_req, 0);

      // R11 arm ignored while busy
      start_run(3, 0, 1, 0);
      repeat (5) @(negedge clk);
      unit_count = CNT_W'(1); arm = 1'b1; @(negedge clk); arm = 1'b0;
      wait_idle();
      chk(rd_cnt == 3, "R11", "arm while busy ignored", rd_cnt, 3);

      // R13 zero count
      start_run(0, 0, 0, 0);
      chk(done && !bus_req && !busy, "R13", "zero count done pulse", done, 1);
      @(negedge clk);
      chk(!done, "R13", "zero count pulse ends", done, 0);

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule